// File: doc/BRIEF.md
# Reset Source Capture Unit

This block keeps a record of which event last reset a small microcontroller, so that early boot software can tell why the device restarted. Four already-synchronised single-cycle pulses come in: power-on, external reset pin, watchdog expiry and voltage-monitor trip. Each reset source has its own sticky flag. Software reads the flags at one I/O address and clears them by writing zeros. Each flag has its own rule for which resets may clear it.

The block also applies the voltage-monitor trigger policy, which a 3-bit level code selects. Depending on the code, a monitor trip is ignored, turned into an ordinary power-on reset, or latched into a monitor flag that can raise an interrupt. The monitor flag is read and cleared through a second register address. Every reset-class event also produces a registered system reset request. The analog comparator, its thresholds, the watchdog timer and the CPU are outside this block.

Top module: `rst_cause_unit`

## Requirements
- R1: A read at address 0x3B returns the watchdog flag on bit 3, the external flag on bit 1 and the power-on flag on bit 0. Bits 7:4 and bit 2 read as 0. An address that is neither 0x3B nor 0x3A reads as 0.
- R2: A read at address 0x3A returns the monitor flag on bit 0 and 0 on bits 7:1.
- R3: A watchdog pulse sets the watchdog flag from the next cycle on.
- R4: An external-pin pulse sets the external flag from the next cycle on.
- R5: A power-on event sets the power-on flag and clears the watchdog and external flags in the next cycle. The exception is a watchdog or external pulse in the same cycle, whose flag is set instead.
- R6: A write to 0x3B clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. The power-on flag is cleared only by such a write.
- R7: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set. This applies to the monitor flag as well.
- R8: With level code 000, 101, 110 or 111, a monitor pulse changes no flag and requests no reset.
- R9: With level code 001 or 010, a monitor pulse acts exactly like a power-on event (R5, R11) and leaves the monitor flag unchanged.
- R10: With level code 011 or 100, a monitor pulse sets the monitor flag. A write of 0 to bit 0 at 0x3A clears it. The interrupt output equals the monitor flag AND the interrupt enable.
- R11: The system reset request is high for the cycle after a power-on, external, watchdog or power-on-mapped monitor pulse, and low otherwise.
- R12: After the synchronous reset, all flags, the reset request and the interrupt read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_evt | input | 1 | Power-on reset pulse |
| ext_evt | input | 1 | External pin reset pulse |
| wdt_evt | input | 1 | Watchdog reset pulse |
| mon_evt | input | 1 | Voltage-monitor trip pulse |
| mon_level | input | 3 | Monitor trigger level code |
| mon_ie | input | 1 | Monitor interrupt enable |
| bus_addr | input | 6 | Register bus I/O address |
| bus_we | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| sys_rst_req | output | 1 | Registered system reset request |
| mon_flag | output | 1 | Monitor flag |
| mon_irq | output | 1 | Monitor interrupt request |

## Verification
The assertions assume that each event input is a clean single-cycle pulse sampled on the rising edge. They also assume that the level code and the bus signals are stable around that edge, so that the cycle after an event shows its effect. The stimulus drives every input on the falling edge only. It draws event pulses at low rates, sometimes several in one cycle, picks every one of the eight level codes, and aims most writes at the two live addresses. In this way simultaneous set and clear collisions occur often, while no input ever changes near the sampling edge.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int LVL_W   = 3;
    localparam int WDT_POS = 3;
    localparam int EXT_POS = 1;
    localparam int POR_POS = 0;
    localparam int MON_POS = 0;

    typedef enum logic [1:0] {
        MON_IGNORE  = 2'd0,
        MON_AS_POR  = 2'd1,
        MON_AS_FLAG = 2'd2
    } mon_act_e;

    typedef struct packed {
        logic wdt;
        logic ext;
        logic por;
    } rst_flags_t;

    typedef struct packed {
        logic por_cls;
        logic ext;
        logic wdt;
        logic mon_set;
    } evt_t;

    typedef struct packed {
        logic wdt;
        logic ext;
        logic por;
        logic mon;
    } clr_t;

    function automatic mon_act_e lvl_to_act(input logic [LVL_W-1:0] lvl);
        mon_act_e a;
        case (lvl)
            3'd1, 3'd2: a = MON_AS_POR;
            3'd3, 3'd4: a = MON_AS_FLAG;
            default:    a = MON_IGNORE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/rsc_mon_policy.sv
module rsc_mon_policy
    import rsc_pkg::*;
(
    input  logic             por_evt,
    input  logic             ext_evt,
    input  logic             wdt_evt,
    input  logic             mon_evt,
    input  logic [LVL_W-1:0] mon_level,
    output evt_t             evts
);
    mon_act_e act;

    always_comb begin
        act          = lvl_to_act(mon_level);
        evts.por_cls = por_evt | (mon_evt & (act == MON_AS_POR));
        evts.ext     = ext_evt;
        evts.wdt     = wdt_evt;
        evts.mon_set = mon_evt & (act == MON_AS_FLAG);
    end
endmodule

// File: rtl/rsc_bus_dec.sv
module rsc_bus_dec
    import rsc_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] MON_ADDR  = 6'h3A
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  rst_flags_t        flags,
    input  logic              mon_flag,
    output clr_t              clr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic hit_flag;
    logic hit_mon;

    always_comb begin
        hit_flag = (bus_addr == FLAG_ADDR);
        hit_mon  = (bus_addr == MON_ADDR);

        clr.wdt = bus_we & hit_flag & ~bus_wdata[WDT_POS];
        clr.ext = bus_we & hit_flag & ~bus_wdata[EXT_POS];
        clr.por = bus_we & hit_flag & ~bus_wdata[POR_POS];
        clr.mon = bus_we & hit_mon  & ~bus_wdata[MON_POS];

        bus_rdata = '0;
        if (hit_flag) begin
            bus_rdata[WDT_POS] = flags.wdt;
            bus_rdata[EXT_POS] = flags.ext;
            bus_rdata[POR_POS] = flags.por;
        end else if (hit_mon) begin
            bus_rdata[MON_POS] = mon_flag;
        end
    end
endmodule

// File: rtl/rsc_flag_reg.sv
module rsc_flag_reg
    import rsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evts,
    input  clr_t       clr,
    output rst_flags_t flags_q,
    output logic       mon_q,
    output logic       req_q
);
    rst_flags_t flags_d;
    logic       mon_d;
    logic       req_d;

    always_comb begin
        // set beats clear; power-on class wipes watchdog and external
        flags_d.wdt = evts.wdt | (flags_q.wdt & ~evts.por_cls & ~clr.wdt);
        flags_d.ext = evts.ext | (flags_q.ext & ~evts.por_cls & ~clr.ext);
        flags_d.por = evts.por_cls | (flags_q.por & ~clr.por);
        mon_d       = evts.mon_set | (mon_q & ~clr.mon);
        req_d       = evts.por_cls | evts.ext | evts.wdt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            mon_q   <= 1'b0;
            req_q   <= 1'b0;
        end else begin
            flags_q <= flags_d;
            mon_q   <= mon_d;
            req_q   <= req_d;
        end
    end
endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
    import rsc_pkg::*;
#(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] MON_ADDR  = 6'h3A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_evt,
    input  logic              ext_evt,
    input  logic              wdt_evt,
    input  logic              mon_evt,
    input  logic [2:0]        mon_level,
    input  logic              mon_ie,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req,
    output logic              mon_flag,
    output logic              mon_irq
);
    evt_t       evts;
    clr_t       clr;
    rst_flags_t flags_q;
    logic       mon_q;

    rsc_mon_policy u_policy (
        .por_evt   (por_evt),
        .ext_evt   (ext_evt),
        .wdt_evt   (wdt_evt),
        .mon_evt   (mon_evt),
        .mon_level (mon_level),
        .evts      (evts)
    );

    rsc_bus_dec #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FLAG_ADDR (FLAG_ADDR),
        .MON_ADDR  (MON_ADDR)
    ) u_bus (
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .flags     (flags_q),
        .mon_flag  (mon_q),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    rsc_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .evts    (evts),
        .clr     (clr),
        .flags_q (flags_q),
        .mon_q   (mon_q),
        .req_q   (sys_rst_req)
    );

    assign mon_flag = mon_q;
    assign mon_irq  = mon_q & mon_ie;
endmodule

// File: rtl/rst_cause_unit_chk.sv
module rst_cause_unit_chk #(
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3B
) (
    input logic              clk,
    input logic              rst,
    input logic              por_evt,
    input logic              ext_evt,
    input logic              wdt_evt,
    input logic              mon_evt,
    input logic [2:0]        mon_level,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sys_rst_req,
    input logic              mon_flag,
    input logic              flag_wdt,
    input logic              flag_ext,
    input logic              flag_por
);
    logic lvl_off, lvl_por, lvl_flag, quiet;
    assign lvl_off  = (mon_level == 3'd0) || (mon_level > 3'd4);
    assign lvl_por  = (mon_level == 3'd1) || (mon_level == 3'd2);
    assign lvl_flag = (mon_level == 3'd3) || (mon_level == 3'd4);
    assign quiet    = !por_evt && !ext_evt && !wdt_evt && !bus_we;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == FLAG_ADDR) |-> (bus_rdata[DATA_W-1:4] == '0 && !bus_rdata[2])); // R1
    AST_WDT_SETS: assert property (@(posedge clk) disable iff (rst)
        wdt_evt |=> flag_wdt); // R3
    AST_EXT_SETS: assert property (@(posedge clk) disable iff (rst)
        ext_evt |=> flag_ext); // R4
    AST_POR_WIPES: assert property (@(posedge clk) disable iff (rst)
        (por_evt && !ext_evt && !wdt_evt) |=> (flag_por && !flag_ext && !flag_wdt)); // R5
    AST_ONES_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == FLAG_ADDR && bus_wdata[3] && bus_wdata[1] && bus_wdata[0]
         && !por_evt && !ext_evt && !wdt_evt && !(mon_evt && lvl_por))
        |=> $stable({flag_wdt, flag_ext, flag_por})); // R6
    AST_MON_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (mon_evt && lvl_off && quiet)
        |=> ($stable({flag_wdt, flag_ext, flag_por, mon_flag}) && !sys_rst_req)); // R8
    AST_MON_TO_POR: assert property (@(posedge clk) disable iff (rst)
        (mon_evt && lvl_por) |=> (flag_por && sys_rst_req)); // R9
    AST_MON_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (mon_evt && lvl_flag) |=> mon_flag); // R10
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!por_evt && !ext_evt && !wdt_evt && !(mon_evt && lvl_por)) |=> !sys_rst_req); // R11
endmodule

bind rst_cause_unit rst_cause_unit_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .FLAG_ADDR (FLAG_ADDR)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .por_evt     (por_evt),
    .ext_evt     (ext_evt),
    .wdt_evt     (wdt_evt),
    .mon_evt     (mon_evt),
    .mon_level   (mon_level),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .sys_rst_req (sys_rst_req),
    .mon_flag    (mon_flag),
    .flag_wdt    (flags_q.wdt),
    .flag_ext    (flags_q.ext),
    .flag_por    (flags_q.por)
);

// File: tb/rst_cause_unit_tb_top.sv
module rst_cause_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       por_evt, ext_evt, wdt_evt, mon_evt, mon_ie, bus_we;
    logic [2:0] mon_level;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       sys_rst_req, mon_flag, mon_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model state
    logic m_wdt = 0, m_ext = 0, m_por = 0, m_mon = 0, m_req = 0;

    always #2 clk = ~clk;

    rst_cause_unit dut_i (
        .clk(clk), .rst(rst), .por_evt(por_evt), .ext_evt(ext_evt),
        .wdt_evt(wdt_evt), .mon_evt(mon_evt), .mon_level(mon_level),
        .mon_ie(mon_ie), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sys_rst_req(sys_rst_req), .mon_flag(mon_flag), .mon_irq(mon_irq)
    );

    function automatic logic [7:0] exp_rdata(input logic [5:0] a);
        logic [7:0] r = 8'h00;
        if (a == 6'h3B) begin r[3] = m_wdt; r[1] = m_ext; r[0] = m_por; end
        else if (a == 6'h3A) r[0] = m_mon;
        return r;
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        logic por_cls, wr_f, wr_m, ms;
        por_cls = por_evt | (mon_evt & (mon_level == 3'd1 || mon_level == 3'd2));
        ms      = mon_evt & (mon_level == 3'd3 || mon_level == 3'd4);
        wr_f    = bus_we & (bus_addr == 6'h3B);
        wr_m    = bus_we & (bus_addr == 6'h3A);
        m_req   = por_cls | ext_evt | wdt_evt;
        m_wdt   = wdt_evt | (m_wdt & ~por_cls & ~(wr_f & ~bus_wdata[3]));
        m_ext   = ext_evt | (m_ext & ~por_cls & ~(wr_f & ~bus_wdata[1]));
        m_por   = por_cls | (m_por & ~(wr_f & ~bus_wdata[0]));
        m_mon   = ms | (m_mon & ~(wr_m & ~bus_wdata[0]));
    endtask

    task automatic step(input string tag, input logic p, input logic e, input logic w,
                        input logic m, input logic [2:0] lv, input logic ie,
                        input logic we, input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        por_evt = p; ext_evt = e; wdt_evt = w; mon_evt = m; mon_level = lv;
        mon_ie = ie; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        check(tag, "rdata", bus_rdata, exp_rdata(a));
        check(tag, "sys_rst_req(R11)", {7'd0, sys_rst_req}, {7'd0, m_req});
        check(tag, "mon_flag(R10)", {7'd0, mon_flag}, {7'd0, m_mon});
        check(tag, "mon_irq(R10)", {7'd0, mon_irq}, {7'd0, m_mon & ie});
        model_update();
    endtask

    task automatic idle(input string tag, input logic [5:0] a);
        step(tag, 0, 0, 0, 0, 3'd0, 1'b1, 0, a, 8'h00);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        rst = 1'b1;
        por_evt = 0; ext_evt = 0; wdt_evt = 0; mon_evt = 0; mon_level = 0;
        mon_ie = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        idle("R12", 6'h3B);
        idle("R12", 6'h3A);
        // R5 power-on, R11 request
        step("R5", 1, 0, 0, 0, 3'd0, 1, 0, 6'h3B, 8'h00);
        idle("R11", 6'h3B);
        // R3, R4
        step("R3", 0, 0, 1, 0, 3'd0, 1, 0, 6'h3B, 8'h00);
        idle("R3", 6'h3B);
        step("R4", 0, 1, 0, 0, 3'd0, 1, 0, 6'h3B, 8'h00);
        idle("R4", 6'h3B);
        idle("R1", 6'h15);
        // R5 wipes ext and wdt; then same-cycle ext keeps it
        step("R5", 1, 0, 0, 0, 3'd0, 1, 0, 6'h3B, 8'h00);
        idle("R5", 6'h3B);
        step("R5", 1, 1, 0, 0, 3'd0, 1, 0, 6'h3B, 8'h00);
        idle("R5", 6'h3B);
        // R6 write ones keeps, write zero clears
        step("R6", 0, 0, 0, 0, 3'd0, 1, 1, 6'h3B, 8'hFF);
        idle("R6", 6'h3B);
        step("R6", 0, 0, 0, 0, 3'd0, 1, 1, 6'h3B, 8'hFE);
        idle("R6", 6'h3B);
        step("R6", 0, 0, 0, 0, 3'd0, 1, 1, 6'h3B, 8'h00);
        idle("R6", 6'h3B);
        // R7 set wins over clear
        step("R7", 0, 0, 1, 0, 3'd0, 1, 1, 6'h3B, 8'h00);
        idle("R7", 6'h3B);
        // R8 ignored codes
        step("R8", 0, 0, 0, 1, 3'd0, 1, 0, 6'h3B, 8'h00);
        idle("R8", 6'h3B);
        step("R8", 0, 0, 0, 1, 3'd5, 1, 0, 6'h3A, 8'h00);
        idle("R8", 6'h3A);
        step("R8", 0, 0, 0, 1, 3'd6, 1, 0, 6'h3B, 8'h00);
        step("R8", 0, 0, 0, 1, 3'd7, 1, 0, 6'h3B, 8'h00);
        idle("R8", 6'h3B);
        // R9 monitor as power-on
        step("R9", 0, 0, 0, 1, 3'd1, 1, 0, 6'h3B, 8'h00);
        idle("R9", 6'h3B);
        step("R9", 0, 0, 0, 1, 3'd2, 1, 1, 6'h3B, 8'h00);
        idle("R9", 6'h3A);
        // R10 monitor flag and interrupt, R2 readback
        step("R10", 0, 0, 0, 1, 3'd3, 1, 0, 6'h3A, 8'h00);
        idle("R2", 6'h3A);
        step("R10", 0, 0, 0, 0, 3'd0, 0, 1, 6'h3A, 8'hFF);
        step("R10", 0, 0, 0, 0, 3'd0, 1, 1, 6'h3A, 8'h00);
        idle("R10", 6'h3A);
        step("R10", 0, 0, 0, 1, 3'd4, 0, 0, 6'h3A, 8'h00);
        step("R7", 0, 0, 0, 1, 3'd4, 0, 1, 6'h3A, 8'h00);
        idle("R2", 6'h3A);
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] a;
            int sel = $urandom_range(0, 9);
            a = (sel < 4) ? 6'h3B : (sel < 8) ? 6'h3A : 6'($urandom);
            step("R1", ($urandom_range(0, 19) == 0), ($urandom_range(0, 19) == 0),
                 ($urandom_range(0, 19) == 0), ($urandom_range(0, 4) == 0),
                 3'($urandom), 1'($urandom), ($urandom_range(0, 2) == 0), a, 8'($urandom));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule